// File: doc/BRIEF.md
# Shared Queue-Threshold Status Bus

This block watches the fill level of every queue in a multi-queue buffer and publishes one active-low threshold flag per queue on a narrow status bus. Queues that are not selected on a data port can still be observed. With `FULL_SIDE` set, a flag means "almost full": the free space has fallen to the queue's offset or below. With `FULL_SIDE` cleared, it means "almost empty": the stored word count is at or below the offset. Each queue has its own offset. The offsets come up at reset with one of two defaults and can be rewritten later.

Up to eight devices can share one status bus. The bus is not tri-stated here; the block drives its value together with a separate output-enable, `bus_oe_o`. Bus ownership works in one of two modes, and the mode is captured while reset is held:
- **Polled:** a token ring. A device owns the bus in the cycle after it receives the token. While it owns the bus it raises its token output and its sync output.
- **Direct:** a strobe selects a device. The device-address field is compared with the device's own identifier, which is also captured at reset.

After reset the master device owns the bus first. The block has no streaming data interface, so no valid/ready handshake applies. Every pin is a plain control or status level sampled on the rising clock edge. There is no back-pressure.

Top module: `qsb_top`

## Requirements
- R1: While reset is held and in the cycle after reset is released, `bus_oe_o` equals the captured master input, every `flag_bus_o` bit is 1, and `tok_o`/`sync_o` equal master AND polled mode.
- R2: Bit i of `flag_bus_o` is 0 when queue i is configured and its metric is at or below its offset. The metric is QDEPTH minus level when FULL_SIDE=1, and the level itself when FULL_SIDE=0. Otherwise bit i is 1.
- R3: Bit i of `flag_bus_o` stays 1 whenever bit i of `q_active_i` is 0, whatever the queue's level.
- R4: At reset every offset loads 8 when `big_dflt_i` is 0 and 128 when it is 1. Changing `big_dflt_i` after reset has no effect.
- R5: A write with `ofs_we_i`=1 stores `ofs_val_i` as the offset of queue `ofs_sel_i`. The clock edge that performs the write still compares against the old offset, and the flags from the following edge on use the new one.
- R6: The polled/direct mode, the master input and the device identifier are captured only while reset is held. Later changes on those pins have no effect.
- R7: In polled mode, ownership after each edge equals `tok_i` before that edge. `tok_o` and `sync_o` are 1 exactly while the device owns the bus.
- R8: In polled mode, `strobe_i` and `sel_addr_i` have no effect on ownership.
- R9: In direct mode, an edge with `strobe_i`=1 makes the device owner when `sel_addr_i[5:3]` equals its identifier, and non-owner otherwise. The queue field `sel_addr_i[2:0]` is ignored.
- R10: In direct mode, ownership holds while `strobe_i`=0. `tok_i` is ignored, and `tok_o` and `sync_o` stay 0.
- R11: `flag_bus_o` is registered: a change in level, configuration or offset shows on the bus after the next rising edge, not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset; configuration pins are captured while it is low |
| polled_mode_i | input | 1 | 1 = polled token ring, 0 = direct strobe selection (captured at reset) |
| master_i | input | 1 | 1 = this device owns the bus first after reset (captured at reset) |
| dev_id_i | input | 3 | Device identifier (captured at reset) |
| big_dflt_i | input | 1 | Default offset select: 0 gives 8, 1 gives 128 (captured at reset) |
| q_active_i | input | 8 | Per-queue configured mask |
| q_level_i | input | 72 | Packed per-queue word counts, queue i at bits [9i+8:9i] |
| ofs_we_i | input | 1 | Offset write enable |
| ofs_sel_i | input | 3 | Queue whose offset is written |
| ofs_val_i | input | 9 | New offset value |
| strobe_i | input | 1 | Direct-mode selection strobe |
| sel_addr_i | input | 6 | Device field [5:3] and queue field [2:0] |
| tok_i | input | 1 | Token from the previous device in the ring |
| flag_bus_o | output | 8 | Active-low per-queue threshold flags |
| bus_oe_o | output | 1 | 1 while this device owns the status bus |
| tok_o | output | 1 | Token to the next device in the ring |
| sync_o | output | 1 | High during the cycle this device's status is on the bus |

## Verification
The bench builds the block with its defaults: eight queues, 9-bit levels, a queue depth of 256 and the almost-full flavour. With these values both default offsets can be reached, as can levels that sit exactly on a threshold, one word off it, and a completely full queue. It runs one device through several resets to cover each combination of polled and direct mode, master and slave, and both default offsets. The ring is closed by driving `tok_i` from the bench. In direct mode the strobe sequences use both matching and foreign device fields, and queue fields of 0, 2 and 7.

// File: rtl/qsb_pkg.sv
package qsb_pkg;
  localparam int unsigned DFLT_OFS_LO = 8;
  localparam int unsigned DFLT_OFS_HI = 128;

  typedef enum logic {
    ARB_DIRECT = 1'b0,
    ARB_POLLED = 1'b1
  } arb_mode_e;
endpackage

// File: rtl/qsb_offsets.sv
module qsb_offsets #(
  parameter int unsigned NQ     = 8,
  parameter int unsigned CNT_W  = 9,
  parameter int unsigned QSEL_W = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       big_dflt_i,
  input  logic                       we_i,
  input  logic [QSEL_W-1:0]          sel_i,
  input  logic [CNT_W-1:0]           val_i,
  output logic [NQ-1:0][CNT_W-1:0]   ofs_o
);
  import qsb_pkg::*;

  localparam logic [CNT_W-1:0] OFS_LO = CNT_W'(DFLT_OFS_LO);
  localparam logic [CNT_W-1:0] OFS_HI = CNT_W'(DFLT_OFS_HI);

  for (genvar i = 0; i < NQ; i++) begin : g_ofs
    always_ff @(posedge clk) begin
      if (!rst_n)
        ofs_o[i] <= big_dflt_i ? OFS_HI : OFS_LO;
      else if (we_i && (sel_i == QSEL_W'(i)))
        ofs_o[i] <= val_i;
    end

    p_ofs_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (we_i && sel_i == QSEL_W'(i)) |=> (ofs_o[i] == $past(val_i)));
    p_ofs_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!we_i) |=> $stable(ofs_o[i]));
  end
endmodule

// File: rtl/qsb_thresh.sv
module qsb_thresh #(
  parameter int unsigned NQ        = 8,
  parameter int unsigned CNT_W     = 9,
  parameter int unsigned QDEPTH    = 256,
  parameter bit          FULL_SIDE = 1'b1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NQ-1:0]             active_i,
  input  logic [NQ*CNT_W-1:0]       level_i,
  input  logic [NQ-1:0][CNT_W-1:0]  ofs_i,
  output logic [NQ-1:0]             flags_o
);
  localparam int unsigned MW = CNT_W + 1;
  localparam logic [MW-1:0] DEPTH_M = MW'(QDEPTH);

  for (genvar i = 0; i < NQ; i++) begin : g_cmp
    logic [MW-1:0] lvl_m;
    logic [MW-1:0] metric;
    logic          hit;

    assign lvl_m = {1'b0, level_i[i*CNT_W +: CNT_W]};

    if (FULL_SIDE) begin : g_free
      assign metric = DEPTH_M - lvl_m;
    end else begin : g_used
      assign metric = lvl_m;
    end

    assign hit = active_i[i] && (metric <= {1'b0, ofs_i[i]});

    always_ff @(posedge clk) begin
      if (!rst_n) flags_o[i] <= 1'b1;
      else        flags_o[i] <= ~hit;
    end

    p_unconf_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!active_i[i]) |=> flags_o[i]);
  end
endmodule

// File: rtl/qsb_arbiter.sv
module qsb_arbiter #(
  parameter int unsigned DEV_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             polled_mode_i,
  input  logic             master_i,
  input  logic [DEV_W-1:0] dev_id_i,
  input  logic             strobe_i,
  input  logic [DEV_W-1:0] sel_dev_i,
  input  logic             tok_i,
  output logic             own_o,
  output logic             polled_o
);
  import qsb_pkg::*;

  arb_mode_e        mode_q;
  logic [DEV_W-1:0] id_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= polled_mode_i ? ARB_POLLED : ARB_DIRECT;
      id_q   <= dev_id_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      own_o <= master_i;
    else if (mode_q == ARB_POLLED)
      own_o <= tok_i;
    else if (strobe_i)
      own_o <= (sel_dev_i == id_q);
  end

  assign polled_o = (mode_q == ARB_POLLED);

  p_mode_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ($stable(mode_q) && $stable(id_q)));
  p_token_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    polled_o |=> (own_o == $past(tok_i)));
  p_strobe_pick_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!polled_o && strobe_i) |=> (own_o == ($past(sel_dev_i) == id_q)));
  p_direct_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!polled_o && !strobe_i) |=> $stable(own_o));
endmodule

// File: rtl/qsb_top.sv
module qsb_top #(
  parameter int unsigned NQ        = 8,
  parameter int unsigned CNT_W     = 9,
  parameter int unsigned QDEPTH    = 256,
  parameter int unsigned DEV_W     = 3,
  parameter bit          FULL_SIDE = 1'b1,
  localparam int unsigned QSEL_W   = $clog2(NQ),
  localparam int unsigned ADDR_W   = DEV_W + QSEL_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 polled_mode_i,
  input  logic                 master_i,
  input  logic [DEV_W-1:0]     dev_id_i,
  input  logic                 big_dflt_i,
  input  logic [NQ-1:0]        q_active_i,
  input  logic [NQ*CNT_W-1:0]  q_level_i,
  input  logic                 ofs_we_i,
  input  logic [QSEL_W-1:0]    ofs_sel_i,
  input  logic [CNT_W-1:0]     ofs_val_i,
  input  logic                 strobe_i,
  input  logic [ADDR_W-1:0]    sel_addr_i,
  input  logic                 tok_i,
  output logic [NQ-1:0]        flag_bus_o,
  output logic                 bus_oe_o,
  output logic                 tok_o,
  output logic                 sync_o
);
  logic [NQ-1:0][CNT_W-1:0] ofs;
  logic                     own;
  logic                     polled;

  qsb_offsets #(.NQ(NQ), .CNT_W(CNT_W), .QSEL_W(QSEL_W)) u_ofs (
    .clk(clk), .rst_n(rst_n), .big_dflt_i(big_dflt_i),
    .we_i(ofs_we_i), .sel_i(ofs_sel_i), .val_i(ofs_val_i), .ofs_o(ofs)
  );

  qsb_thresh #(.NQ(NQ), .CNT_W(CNT_W), .QDEPTH(QDEPTH), .FULL_SIDE(FULL_SIDE)) u_thr (
    .clk(clk), .rst_n(rst_n), .active_i(q_active_i),
    .level_i(q_level_i), .ofs_i(ofs), .flags_o(flag_bus_o)
  );

  qsb_arbiter #(.DEV_W(DEV_W)) u_arb (
    .clk(clk), .rst_n(rst_n), .polled_mode_i(polled_mode_i),
    .master_i(master_i), .dev_id_i(dev_id_i), .strobe_i(strobe_i),
    .sel_dev_i(sel_addr_i[ADDR_W-1 -: DEV_W]), .tok_i(tok_i),
    .own_o(own), .polled_o(polled)
  );

  assign bus_oe_o = own;
  assign tok_o    = polled & own;
  assign sync_o   = polled & own;

  p_direct_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!polled) |-> (!tok_o && !sync_o));
  p_sync_owner_r7: assert property (@(posedge clk) disable iff (!rst_n)
    polled |-> (sync_o == bus_oe_o && tok_o == bus_oe_o));
endmodule

// File: tb/sim_qsb_top.sv
module sim_qsb_top;
  localparam int NQ = 8, CW = 9;

  logic clk = 1'b0, rst_n = 1'b0;
  logic polled_mode_i = 1'b1, master_i = 1'b1, big_dflt_i = 1'b0;
  logic [2:0] dev_id_i = '0;
  logic [NQ-1:0] q_active_i = '1;
  logic [NQ*CW-1:0] q_level_i = '0;
  logic ofs_we_i = 1'b0;
  logic [2:0] ofs_sel_i = '0;
  logic [CW-1:0] ofs_val_i = '0;
  logic strobe_i = 1'b0;
  logic [5:0] sel_addr_i = '0;
  logic tok_i = 1'b0;
  logic [NQ-1:0] flag_bus_o;
  logic bus_oe_o, tok_o, sync_o;

  int checks = 0, errors = 0;

  typedef struct {
    logic [7:0] bus;
    logic oe, tok, sync;
    string tag;
  } exp_t;
  exp_t exp_q[$];

  always #5 clk = ~clk;

  qsb_top u0 (.*);

  task automatic compare(exp_t e);
    checks++;
    if (flag_bus_o !== e.bus || bus_oe_o !== e.oe || tok_o !== e.tok || sync_o !== e.sync) begin
      errors++;
      $display("FAIL %s: bus=%h oe=%b tok=%b sync=%b expected bus=%h oe=%b tok=%b sync=%b",
               e.tag, flag_bus_o, bus_oe_o, tok_o, sync_o, e.bus, e.oe, e.tok, e.sync);
    end
  endtask

  // monitor: pops one expectation shortly after each rising edge
  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) compare(exp_q.pop_front());
  end

  // driver: inputs already set; expectation is for the coming edge
  task automatic step(logic [7:0] b, logic oe, logic tk, logic sy, string tag);
    exp_t e;
    e.bus = b; e.oe = oe; e.tok = tk; e.sync = sy; e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk);
  endtask

  task automatic set_lvl(int q, int v);
    q_level_i[q*CW +: CW] = CW'(v);
  endtask

  task automatic do_reset(logic pm, logic ms, logic [2:0] id, logic bd, string tag);
    exp_t e;
    @(negedge clk);
    rst_n = 1'b0; polled_mode_i = pm; master_i = ms; dev_id_i = id; big_dflt_i = bd;
    strobe_i = 1'b0; ofs_we_i = 1'b0; q_level_i = '0; q_active_i = '1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1;
    e.bus = 8'hFF; e.oe = ms; e.tok = ms & pm; e.sync = ms & pm; e.tag = tag;
    compare(e);
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // polled master, default offset 8
    tok_i = 1'b1;
    do_reset(1'b1, 1'b1, 3'd0, 1'b0, "R1 polled master reset");
    step(8'hFF, 1, 1, 1, "R7 token kept");
    tok_i = 1'b0;
    step(8'hFF, 0, 0, 0, "R7 token passed on");
    tok_i = 1'b1;
    step(8'hFF, 1, 1, 1, "R7 token returned");
    tok_i = 1'b0; strobe_i = 1'b1; sel_addr_i = 6'b000_000;
    step(8'hFF, 0, 0, 0, "R8 strobe ignored in polled");
    strobe_i = 1'b0; polled_mode_i = 1'b0; tok_i = 1'b1;
    step(8'hFF, 1, 1, 1, "R6 mode pin change ignored");
    polled_mode_i = 1'b1;
    q_active_i = 8'h7F;
    set_lvl(2, 248); set_lvl(5, 247); set_lvl(6, 256); set_lvl(7, 256);
    step(8'hBB, 1, 1, 1, "R2 R3 R11 thresholds and unconfigured");
    set_lvl(2, 0); set_lvl(4, 249);
    step(8'hAF, 1, 1, 1, "R2 one below threshold");
    ofs_we_i = 1'b1; ofs_sel_i = 3'd5; ofs_val_i = 9'd9;
    step(8'hAF, 1, 1, 1, "R5 write edge uses old offset");
    ofs_we_i = 1'b0;
    step(8'h8F, 1, 1, 1, "R5 new offset applied");

    // polled slave, default offset 128
    tok_i = 1'b0;
    do_reset(1'b1, 1'b0, 3'd1, 1'b1, "R1 polled slave reset");
    big_dflt_i = 1'b0;
    set_lvl(1, 128); set_lvl(0, 127);
    step(8'hFD, 0, 0, 0, "R4 default offset 128");

    // direct slave, id 5
    tok_i = 1'b1;
    do_reset(1'b0, 1'b0, 3'd5, 1'b0, "R1 direct slave reset");
    step(8'hFF, 0, 0, 0, "R10 token ignored in direct");
    strobe_i = 1'b1; sel_addr_i = {3'd5, 3'd2};
    step(8'hFF, 1, 0, 0, "R9 strobe selects matching id");
    strobe_i = 1'b0; sel_addr_i = {3'd3, 3'd0};
    step(8'hFF, 1, 0, 0, "R10 ownership holds without strobe");
    strobe_i = 1'b1;
    step(8'hFF, 0, 0, 0, "R9 strobe to other device releases");
    strobe_i = 1'b0; sel_addr_i = {3'd5, 3'd7};
    step(8'hFF, 0, 0, 0, "R10 address alone no effect");
    strobe_i = 1'b1;
    step(8'hFF, 1, 0, 0, "R9 queue field ignored");
    strobe_i = 1'b0; polled_mode_i = 1'b1; tok_i = 1'b0; dev_id_i = 3'd3;
    sel_addr_i = {3'd3, 3'd0};
    step(8'hFF, 1, 0, 0, "R6 mode pin change ignored in direct");
    strobe_i = 1'b1;
    step(8'hFF, 0, 0, 0, "R6 id pin change ignored");
    strobe_i = 1'b0;

    // direct master
    do_reset(1'b0, 1'b1, 3'd2, 1'b0, "R1 direct master reset");
    step(8'hFF, 1, 0, 0, "R10 master holds in direct");

    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule